// File: doc/BRIEF.md
# Address-Match Repeat-Validation Controller

This block sits behind a serial digit-stream front end in a remote-control receiver. The front end reports each received trinary digit as a strobe plus a two-bit code. It also gives a pulse when a word ends and another pulse when the line has been silent long enough to end the transmission. Each word is nine digits long. The leading five digits form an address, and the trailing four carry binary data.

The controller compares each address digit, as it arrives, with a locally configured trinary address, and it collects the data digits. A single matching word never reaches the outputs. Its data is only held as a candidate. The next consecutive word must match the address again and must carry the same four data bits. Only then is the data driven out and the valid flag raised. The flag stays high through further identical words. It drops at the first faulty digit, at a data disagreement, or at end of transmission. The driven data is kept until a newly validated word replaces it.

Digit codes are: 0 = low, 1 = high, 2 = open, 3 = invalid. Address digit i sits in `local_addr[2i+1:2i]`. Data digit j (the (6+j)-th digit of a word) drives `data_out[j]`.

Top module: `addr_repeat_validator`

## Requirements
- R1: Each of the first five digits of a word is compared with the configured address digit of the same position, and all three trinary values (low, high, open) must match exactly.
- R2: The first matching word after the flag was cleared stores its data as a candidate only; `data_out` and `valid_out` do not change.
- R3: A following word with a matching address and data equal to the candidate sets `valid_out` and copies the data to `data_out`, two clock cycles after the `word_end` pulse is sampled; further identical words keep the flag high.
- R4: In a data position, a high code (1) and an open code (2) both decode to 1, and a low code (0) decodes to 0.
- R5: An address digit that does not match clears `valid_out` two cycles after its strobe, without waiting for the end of the word.
- R6: A complete matching word whose data differs from the candidate clears `valid_out`, leaves `data_out` unchanged, and becomes the new candidate.
- R7: A `tx_end` pulse clears `valid_out` and discards the candidate, while `data_out` keeps its value.
- R8: While `rst_n` is low, `valid_out` and `data_out` are all zero.
- R9: After any clearing event (fault, `tx_end` or reset), two fresh consecutive matching words are needed before `valid_out` rises again.
- R10: A word with fewer than nine digits before `word_end`, or with more than nine digits, counts as a mismatch: it clears `valid_out` and discards the candidate.
- R11: An invalid digit code (3) in any position counts as a mismatch, with the same effect as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_addr | input | 10 | Configured address, two bits per trinary digit |
| digit_stb | input | 1 | One-cycle strobe: a digit is present on `digit_code` |
| digit_code | input | 2 | Received digit: 0 low, 1 high, 2 open, 3 invalid |
| word_end | input | 1 | One-cycle pulse at the end of a word |
| tx_end | input | 1 | One-cycle pulse at the end of a transmission (line silent) |
| data_out | output | 4 | Last validated data bits |
| valid_out | output | 1 | Valid-transmission flag |

## Verification
The bench targets the cases where the flag could rise too early or stay up too long:
- A single matching word after a fault or after end of transmission. A design that skipped the repeat rule would raise the flag there.
- Two words that differ only in whether a data digit is high or open. A design that treated open as its own value would drop the flag.
- Words cut short, words with a tenth digit, and words carrying an invalid code. A design that only checked the digits it received would validate these.
- A mismatch in the first address digit. The bench checks that the flag falls before the word ends and that the following good word alone does not bring it back.

// File: rtl/rpt_valid_pkg.sv
package rpt_valid_pkg;
    typedef enum logic [1:0] {
        DIG_LOW  = 2'd0,
        DIG_HIGH = 2'd1,
        DIG_OPEN = 2'd2,
        DIG_BAD  = 2'd3
    } digit_e;
endpackage

// File: rtl/word_framer.sv
module word_framer
    import rpt_valid_pkg::*;
#(
    parameter int ADDR_DIGITS = 5,
    parameter int DATA_DIGITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*ADDR_DIGITS-1:0] addr_i,
    input  logic                     dig_stb_i,
    input  logic [1:0]               dig_code_i,
    input  logic                     eow_i,
    input  logic                     eot_i,
    output logic                     word_ok_o,
    output logic                     fault_o,
    output logic [DATA_DIGITS-1:0]   word_data_o,
    output logic                     eot_o
);
    localparam int TOTAL = ADDR_DIGITS + DATA_DIGITS;
    localparam int IDXW  = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [IDXW-1:0]        idx;
        logic                   err;
        logic [DATA_DIGITS-1:0] data;
        logic                   ok;
        logic                   fault;
        logic                   eot;
    } frame_t;

    frame_t frame_q, frame_d;

    always_comb begin
        logic bad;
        logic [1:0] want;
        frame_d       = frame_q;
        frame_d.ok    = 1'b0;
        frame_d.fault = 1'b0;
        frame_d.eot   = eot_i;
        bad           = 1'b0;
        want          = DIG_LOW;
        if (eot_i) begin
            frame_d.idx = '0;
            frame_d.err = 1'b0;
        end else if (eow_i) begin
            if (!frame_q.err && frame_q.idx == IDXW'(TOTAL))
                frame_d.ok = 1'b1;
            else if (!frame_q.err)
                frame_d.fault = 1'b1;
            frame_d.idx = '0;
            frame_d.err = 1'b0;
        end else if (dig_stb_i) begin
            for (int j = 0; j < ADDR_DIGITS; j++)
                if (frame_q.idx == IDXW'(j)) want = addr_i[2*j +: 2];
            if (dig_code_i == DIG_BAD) begin
                bad = 1'b1;
            end else if (frame_q.idx < IDXW'(ADDR_DIGITS)) begin
                bad = (dig_code_i != want);
            end else if (frame_q.idx < IDXW'(TOTAL)) begin
                for (int j = 0; j < DATA_DIGITS; j++)
                    if (frame_q.idx == IDXW'(ADDR_DIGITS + j))
                        frame_d.data[j] = (dig_code_i != DIG_LOW);
            end else begin
                bad = 1'b1;
            end
            if (frame_q.idx != IDXW'(TOTAL))
                frame_d.idx = frame_q.idx + 1'b1;
            if (bad && !frame_q.err) begin
                frame_d.err   = 1'b1;
                frame_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_q <= '0;
        else        frame_q <= frame_d;
    end

    assign word_ok_o   = frame_q.ok;
    assign fault_o     = frame_q.fault;
    assign word_data_o = frame_q.data;
    assign eot_o       = frame_q.eot;

    // R10: a finished word and a fault are never reported together
    assert_ok_excludes_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ok_o && fault_o));

    // R11: an invalid code in a clean word raises a fault on the next cycle
    assert_bad_code_faults_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_stb_i && !eow_i && !eot_i && dig_code_i == 2'd3 && !frame_q.err) |=> fault_o);
endmodule

// File: rtl/repeat_validator.sv
module repeat_validator #(
    parameter int DATA_DIGITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_ok_i,
    input  logic                   fault_i,
    input  logic [DATA_DIGITS-1:0] word_data_i,
    input  logic                   eot_i,
    output logic [DATA_DIGITS-1:0] data_o,
    output logic                   valid_o
);
    typedef struct packed {
        logic [DATA_DIGITS-1:0] stored;
        logic                   have;
        logic [DATA_DIGITS-1:0] dout;
        logic                   valid;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (eot_i || fault_i) begin
            hold_d.valid = 1'b0;
            hold_d.have  = 1'b0;
        end else if (word_ok_i) begin
            if (hold_q.have && word_data_i == hold_q.stored) begin
                hold_d.valid = 1'b1;
                hold_d.dout  = word_data_i;
            end else begin
                hold_d.valid = 1'b0;
            end
            hold_d.stored = word_data_i;
            hold_d.have   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign data_o  = hold_q.dout;
    assign valid_o = hold_q.valid;

    // R3: the driven data only moves while the flag is being set
    assert_dout_moves_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o);

    // R5: a fault from the framer drops the flag on the next edge
    assert_fault_clears_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !valid_o);

    // R7: end of transmission drops the flag
    assert_eot_clears_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eot_i |=> !valid_o);

    // R9: the flag only rises right after a completed word
    assert_rise_after_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(word_ok_i));
endmodule

// File: rtl/addr_repeat_validator.sv
module addr_repeat_validator #(
    parameter int ADDR_DIGITS = 5,
    parameter int DATA_DIGITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*ADDR_DIGITS-1:0] local_addr,
    input  logic                     digit_stb,
    input  logic [1:0]               digit_code,
    input  logic                     word_end,
    input  logic                     tx_end,
    output logic [DATA_DIGITS-1:0]   data_out,
    output logic                     valid_out
);
    logic                   word_ok;
    logic                   fault;
    logic                   eot_r;
    logic [DATA_DIGITS-1:0] word_data;

    word_framer #(
        .ADDR_DIGITS(ADDR_DIGITS),
        .DATA_DIGITS(DATA_DIGITS)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (local_addr),
        .dig_stb_i  (digit_stb),
        .dig_code_i (digit_code),
        .eow_i      (word_end),
        .eot_i      (tx_end),
        .word_ok_o  (word_ok),
        .fault_o    (fault),
        .word_data_o(word_data),
        .eot_o      (eot_r)
    );

    repeat_validator #(
        .DATA_DIGITS(DATA_DIGITS)
    ) u_validator (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_ok_i  (word_ok),
        .fault_i    (fault),
        .word_data_i(word_data),
        .eot_i      (eot_r),
        .data_o     (data_out),
        .valid_o    (valid_out)
    );
endmodule

// File: tb/addr_repeat_validator_bench.sv
module addr_repeat_validator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] local_addr;
    logic       digit_stb = 1'b0;
    logic [1:0] digit_code = 2'd0;
    logic       word_end = 1'b0;
    logic       tx_end = 1'b0;
    logic [3:0] data_out;
    logic       valid_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // digits 0..4: high, low, open, low, high
    localparam logic [9:0] GOOD_ADDR = 10'b01_00_10_00_01;
    localparam logic [9:0] BAD_ADDR  = 10'b01_00_01_00_01;

    // {pre_eot, bad_addr, data codes[7:0], exp_valid, exp_dout[3:0]}
    localparam logic [14:0] VEC [11] = '{
        {1'b1, 1'b0, 8'h44, 1'b0, 4'b0000},  // R2 first word held back
        {1'b0, 1'b0, 8'h44, 1'b1, 4'b1010},  // R3 repeat validates
        {1'b0, 1'b0, 8'h44, 1'b1, 4'b1010},  // R3 continuous
        {1'b0, 1'b0, 8'h00, 1'b0, 4'b1010},  // R6 data differs
        {1'b0, 1'b0, 8'h00, 1'b1, 4'b0000},  // R6 new candidate confirmed
        {1'b1, 1'b0, 8'h82, 1'b0, 4'b0000},  // R7 then R2
        {1'b0, 1'b0, 8'h82, 1'b1, 4'b1001},  // R4 open as one
        {1'b0, 1'b0, 8'h41, 1'b1, 4'b1001},  // R4 high equals open
        {1'b0, 1'b1, 8'h41, 1'b0, 4'b1001},  // R1 open vs high in address
        {1'b0, 1'b0, 8'h41, 1'b0, 4'b1001},  // R9 fresh pair needed
        {1'b0, 1'b0, 8'h41, 1'b1, 4'b1001}   // R9 pair complete
    };

    addr_repeat_validator u_addr_repeat_validator (
        .clk       (clk),
        .rst_n     (rst_n),
        .local_addr(local_addr),
        .digit_stb (digit_stb),
        .digit_code(digit_code),
        .word_end  (word_end),
        .tx_end    (tx_end),
        .data_out  (data_out),
        .valid_out (valid_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic ev, input logic [3:0] ed);
        checks++;
        if (valid_out !== ev || data_out !== ed) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%b expected valid=%0b data=%b",
                     tag, valid_out, data_out, ev, ed);
        end
    endtask

    task automatic put_digit(input logic [1:0] c);
        digit_stb = 1'b1; digit_code = c;
        @(negedge clk);
        digit_stb = 1'b0; digit_code = 2'd0;
    endtask

    task automatic pulse_eow();
        word_end = 1'b1; @(negedge clk); word_end = 1'b0;
    endtask

    task automatic pulse_eot();
        tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // sends ndig digits of {extra, data codes, address}, then end of word
    task automatic send_word(input logic [9:0] a, input logic [7:0] dc, input int ndig);
        logic [19:0] w;
        w = {2'b01, dc, a};
        for (int i = 0; i < ndig; i++) put_digit(w[2*i +: 2]);
        pulse_eow();
        settle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        local_addr = GOOD_ADDR;
        repeat (3) @(negedge clk);
        check("R8 reset state", 1'b0, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset release", 1'b0, 4'b0000);

        for (int v = 0; v < 11; v++) begin
            logic [14:0] e;
            e = VEC[v];
            if (e[14]) begin pulse_eot(); settle(); end
            send_word(e[13] ? BAD_ADDR : GOOD_ADDR, e[12:5], 9);
            check(e[4] ? "R3 table vector" : "R2 table vector", e[4], e[3:0]);
        end

        // R7: end of transmission keeps data, clears flag and candidate
        pulse_eot(); settle();
        check("R7 eot clears valid", 1'b0, 4'b1001);
        send_word(GOOD_ADDR, 8'h41, 9);
        check("R7 candidate discarded", 1'b0, 4'b1001);
        send_word(GOOD_ADDR, 8'h41, 9);
        check("R3 revalidate", 1'b1, 4'b1001);

        // R10: short word
        send_word(GOOD_ADDR, 8'h04, 8);
        check("R10 short word", 1'b0, 4'b1001);
        send_word(GOOD_ADDR, 8'h04, 9);
        check("R9 after short word", 1'b0, 4'b1001);
        send_word(GOOD_ADDR, 8'h04, 9);
        check("R3 new data 0010", 1'b1, 4'b0010);

        // R11: invalid code in a data position
        send_word(GOOD_ADDR, 8'hC4, 9);
        check("R11 invalid code", 1'b0, 4'b0010);
        send_word(GOOD_ADDR, 8'h04, 9);
        check("R9 after invalid code", 1'b0, 4'b0010);
        send_word(GOOD_ADDR, 8'h04, 9);
        check("R3 restore", 1'b1, 4'b0010);

        // R10: overlong word
        send_word(GOOD_ADDR, 8'h04, 10);
        check("R10 long word", 1'b0, 4'b0010);
        send_word(GOOD_ADDR, 8'h04, 9);
        send_word(GOOD_ADDR, 8'h04, 9);
        check("R3 restore after long", 1'b1, 4'b0010);

        // R5: first address digit wrong, flag drops before end of word
        put_digit(2'd0);
        @(negedge clk);
        check("R5 immediate clear", 1'b0, 4'b0010);
        for (int i = 1; i < 9; i++) put_digit(2'd1);
        pulse_eow(); settle();
        check("R5 rest of word ignored", 1'b0, 4'b0010);
        send_word(GOOD_ADDR, 8'h04, 9);
        check("R9 after address fault", 1'b0, 4'b0010);

        // R1: a different configured address accepts the matching stream
        local_addr = BAD_ADDR;
        send_word(BAD_ADDR, 8'h11, 9);
        send_word(BAD_ADDR, 8'h11, 9);
        check("R1 other address", 1'b1, 4'b0101);

        // R8: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset clears", 1'b0, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule